// File: doc/BRIEF.md
# Ethernet receive address filter

This block makes the keep-or-discard decision for each frame that arrives from a MAC receive path. For every frame it is given the destination and source addresses, a 6-bit multicast hash index, the frame length in bytes, and three end-of-frame flags: CRC error, length-field error and control frame. The upstream logic raises `rx_valid` for one cycle when all of these are valid. One clock later the block returns a single decision strobe, an accept bit and a 3-bit code. The code names the rule that settled the outcome.

Software programs the block through a small write-only register port. The port holds a 32-bit control word with the override and filter enables, the station address split across two 24-bit halves, a 64-bit multicast hash table and the maximum frame length. The rules are checked in a fixed priority. The pass-everything override comes first. Error screening is next, then broadcast, multicast or unicast matching on the destination. A source-address screen is applied last. Its sense can be inverted.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` is 0, the control word is 0x0000_0100 (only the out-of-range pass bit set), the maximum length is 0x600 and the station address and hash table are zero.
- R2: For every cycle with `rx_valid` high, `dec_valid` is high exactly one cycle later, and it is low in every other cycle.
- R3: Control bit 4 (pass everything) accepts every frame with code 0, whatever the other rules say.
- R4: Without bit 4, a frame is dropped with code 1 if it has a CRC error and bit 6 is clear, a length-field error and bit 7 is clear, or is a control frame and bit 5 is clear.
- R5: Without bit 4, a frame shorter than 64 bytes is always dropped with code 1. A frame longer than the maximum length is dropped with code 1 unless bit 8 is set.
- R6: A destination of all ones is treated as broadcast before the multicast rules. It is accepted with code 2 if bit 22 is set, and dropped with code 2 otherwise.
- R7: Any other destination whose group bit is set is a multicast frame with code 3. The group bit is bit 40 of `rx_dst`, which is the least significant bit of the first address byte. It is accepted only when bit 20 is set and, if bit 21 (hash filtering) is set, the addressed hash bit is also 1.
- R8: Hash index bit 5 selects the hash word: register 4 for 1 and register 3 for 0. Index bits 4:0 select the bit within that word.
- R9: A destination with the group bit clear is unicast, with code 4. It is accepted when bit 17 is clear. When bit 17 is set, it is accepted only if bit 16 is set and the destination equals the station address.
- R10: The station address is {register 1[23:0], register 2[23:0]}. Register 1 holds address bytes 0..2 and register 2 holds bytes 3..5, each with the first byte in bits 23:16. Byte 0 is `rx_dst[47:40]`.
- R11: When bit 24 is set, a frame accepted by the destination rules is dropped with code 5 unless (source equals station address) XOR bit 25 is 1.
- R12: Register addresses are 0 for control, 1 and 2 for the station halves, 3 and 4 for the hash words and 5 for the maximum length (16 bits). A write applies to frames presented from the next cycle on. A write to addresses 6 or 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Frame summary valid, one cycle per frame |
| rx_dst | input | 48 | Destination address, byte 0 in bits 47:40 |
| rx_src | input | 48 | Source address, byte 0 in bits 47:40 |
| rx_hash_idx | input | 6 | Multicast hash index |
| rx_len | input | 16 | Frame length in bytes |
| rx_crc_bad | input | 1 | CRC error flag |
| rx_len_bad | input | 1 | Length-field error flag |
| rx_is_ctrl | input | 1 | Control-frame flag |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 = keep frame, 0 = discard |
| dec_reason | output | 3 | Deciding rule: 0 pass-all, 1 error, 2 broadcast, 3 multicast, 4 unicast, 5 source screen |

## Verification
The only state in this block is the configuration registers, so a wrong register shows up in the decision for the very next frame. A corrupted control bit, station half or hash word flips `dec_accept` or changes `dec_reason` one cycle after such a frame is presented. The bench therefore writes each register and then sends frames that sit on both sides of the rule it feeds. Examples are a hash index in each word, a source address that matches and one that does not, and lengths just inside and just outside the limits. A slip in the priority order shows as a wrong code even when the accept bit happens to agree.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // control word bit positions
    localparam int CB_PASS_ALL  = 4;
    localparam int CB_PASS_CTRL = 5;
    localparam int CB_PASS_CRC  = 6;
    localparam int CB_PASS_LEN  = 7;
    localparam int CB_PASS_OOR  = 8;
    localparam int CB_UCAST_EN  = 16;
    localparam int CB_DA_FILT   = 17;
    localparam int CB_MCAST_EN  = 20;
    localparam int CB_HASH_EN   = 21;
    localparam int CB_BCAST_EN  = 22;
    localparam int CB_SA_FILT   = 24;
    localparam int CB_SA_INV    = 25;

    // register map
    localparam logic [2:0] RA_CTRL   = 3'd0;
    localparam logic [2:0] RA_ST_HI  = 3'd1;
    localparam logic [2:0] RA_ST_LO  = 3'd2;
    localparam logic [2:0] RA_HASH0  = 3'd3;
    localparam logic [2:0] RA_MAXLEN = 3'd5;

    typedef enum logic [2:0] {
        RSN_PASS_ALL = 3'd0,
        RSN_ERROR    = 3'd1,
        RSN_BCAST    = 3'd2,
        RSN_MCAST    = 3'd3,
        RSN_UCAST    = 3'd4,
        RSN_SRC      = 3'd5
    } reason_e;

    typedef struct packed {
        logic    accept;
        reason_e reason;
    } verdict_t;

    function automatic verdict_t mk_verdict(input logic acc, input reason_e rsn);
        verdict_t v;
        v.accept = acc;
        v.reason = rsn;
        return v;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int          CTRL_W     = 32,
    parameter int          HALF_W     = 24,
    parameter int          HWORD_W    = 32,
    parameter int          HASH_WORDS = 2,
    parameter int          LEN_W      = 16,
    parameter logic [31:0] CTRL_RST   = 32'h0000_0100,
    parameter int          MAXLEN_RST = 'h600
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [2:0]                    addr,
    input  logic [31:0]                   wdata,
    output logic [CTRL_W-1:0]             ctrl,
    output logic [2*HALF_W-1:0]           station,
    output logic [HASH_WORDS*HWORD_W-1:0] hash,
    output logic [LEN_W-1:0]              max_len
);
    logic [HALF_W-1:0] st_hi, st_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= CTRL_RST[CTRL_W-1:0];
            st_hi   <= '0;
            st_lo   <= '0;
            max_len <= LEN_W'(MAXLEN_RST);
        end else if (we) begin
            case (addr)
                RA_CTRL:   ctrl    <= wdata[CTRL_W-1:0];
                RA_ST_HI:  st_hi   <= wdata[HALF_W-1:0];
                RA_ST_LO:  st_lo   <= wdata[HALF_W-1:0];
                RA_MAXLEN: max_len <= wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    assign station = {st_hi, st_lo};

    for (genvar g = 0; g < HASH_WORDS; g++) begin : g_hash
        always_ff @(posedge clk) begin
            if (rst)
                hash[g*HWORD_W +: HWORD_W] <= '0;
            else if (we && addr == RA_HASH0 + 3'(g))
                hash[g*HWORD_W +: HWORD_W] <= wdata[HWORD_W-1:0];
        end
    end
endmodule

// File: rtl/rxf_err_check.sv
module rxf_err_check
    import rxf_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              crc_bad,
    input  logic              len_bad,
    input  logic              is_ctrl,
    output logic              drop
);
    logic runt, too_long;

    always_comb begin
        runt     = len < LEN_W'(MIN_LEN);
        too_long = len > max_len;
        drop     = runt
                 | (crc_bad  & ~ctrl[CB_PASS_CRC])
                 | (len_bad  & ~ctrl[CB_PASS_LEN])
                 | (is_ctrl  & ~ctrl[CB_PASS_CTRL])
                 | (too_long & ~ctrl[CB_PASS_OOR]);
    end
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match
    import rxf_pkg::*;
#(
    parameter int CTRL_W  = 32,
    parameter int ADDR_W  = 48,
    parameter int HIDX_W  = 6,
    localparam int HBITS  = 1 << HIDX_W,
    localparam int GRP_B  = ADDR_W - 8
) (
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [ADDR_W-1:0] station,
    input  logic [HBITS-1:0]  hash,
    input  logic [ADDR_W-1:0] da,
    input  logic [ADDR_W-1:0] sa,
    input  logic [HIDX_W-1:0] hidx,
    output verdict_t          verdict
);
    logic bcast, group, da_hit, sa_hit, hash_hit;

    always_comb begin
        bcast    = &da;
        group    = da[GRP_B];
        da_hit   = da == station;
        sa_hit   = sa == station;
        hash_hit = hash[hidx];

        if (bcast)
            verdict = mk_verdict(ctrl[CB_BCAST_EN], RSN_BCAST);
        else if (group)
            verdict = mk_verdict(ctrl[CB_MCAST_EN] && (!ctrl[CB_HASH_EN] || hash_hit),
                                 RSN_MCAST);
        else
            verdict = mk_verdict(!ctrl[CB_DA_FILT] || (ctrl[CB_UCAST_EN] && da_hit),
                                 RSN_UCAST);

        if (verdict.accept && ctrl[CB_SA_FILT] && (sa_hit == ctrl[CB_SA_INV]))
            verdict = mk_verdict(1'b0, RSN_SRC);
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int HIDX_W  = 6,
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64,
    parameter int MAX_LEN = 'h600,
    localparam int CTRL_W = 32,
    localparam int HALF_W = ADDR_W / 2,
    localparam int HWORD_W = 32,
    localparam int HWORDS = (1 << HIDX_W) / HWORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              rx_valid,
    input  logic [ADDR_W-1:0] rx_dst,
    input  logic [ADDR_W-1:0] rx_src,
    input  logic [HIDX_W-1:0] rx_hash_idx,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_crc_bad,
    input  logic              rx_len_bad,
    input  logic              rx_is_ctrl,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_reason
);
    logic [CTRL_W-1:0]         ctrl;
    logic [ADDR_W-1:0]         station;
    logic [HWORDS*HWORD_W-1:0] hash;
    logic [LEN_W-1:0]          max_len;
    logic                      err_drop;
    verdict_t                  addr_v, final_v;

    rxf_cfg_regs #(
        .CTRL_W(CTRL_W), .HALF_W(HALF_W), .HWORD_W(HWORD_W), .HASH_WORDS(HWORDS),
        .LEN_W(LEN_W), .CTRL_RST(32'h0000_0100), .MAXLEN_RST(MAX_LEN)
    ) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl(ctrl), .station(station), .hash(hash), .max_len(max_len)
    );

    rxf_err_check #(.CTRL_W(CTRL_W), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_err (
        .ctrl(ctrl), .len(rx_len), .max_len(max_len), .crc_bad(rx_crc_bad),
        .len_bad(rx_len_bad), .is_ctrl(rx_is_ctrl), .drop(err_drop)
    );

    rxf_addr_match #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .HIDX_W(HIDX_W)) u_addr (
        .ctrl(ctrl), .station(station), .hash(hash), .da(rx_dst), .sa(rx_src),
        .hidx(rx_hash_idx), .verdict(addr_v)
    );

    always_comb begin
        if (ctrl[CB_PASS_ALL])
            final_v = mk_verdict(1'b1, RSN_PASS_ALL);
        else if (err_drop)
            final_v = mk_verdict(1'b0, RSN_ERROR);
        else
            final_v = addr_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_reason <= RSN_PASS_ALL;
        end else begin
            dec_valid <= rx_valid;
            if (rx_valid) begin
                dec_accept <= final_v.accept;
                dec_reason <= final_v.reason;
            end
        end
    end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
    import rxf_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int MIN_LEN = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic [LEN_W-1:0] rx_len,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic [2:0]       dec_reason
);
    // R2: one decision per frame, one cycle later
    p_one_per_frame_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> dec_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !dec_valid);
    // R3: pass-all code always means accept
    p_passall_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_reason == RSN_PASS_ALL) |-> dec_accept);
    // R4: error code always means drop
    p_err_drops_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_reason == RSN_ERROR) |-> !dec_accept);
    // R5: runts only survive through pass-all
    p_runt_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_len < LEN_W'(MIN_LEN)) |=> (!dec_accept || dec_reason == RSN_PASS_ALL));
    // R11: source-screen code always means drop
    p_src_drops_r11: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_reason == RSN_SRC) |-> !dec_accept);
    // R2: code stays within the defined set
    p_reason_range_r2: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> dec_reason <= 3'd5);
endmodule

bind rx_addr_filter rxf_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_len(rx_len),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
);

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic [47:0] rx_dst = '0, rx_src = '0;
    logic [5:0]  rx_hash_idx = '0;
    logic [15:0] rx_len = 16'd100;
    logic        rx_crc_bad = 1'b0, rx_len_bad = 1'b0, rx_is_ctrl = 1'b0;
    logic        dec_valid, dec_accept;
    logic [2:0]  dec_reason;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_ctrl = 32'h100;
    logic [47:0] m_st = '0;
    logic [63:0] m_hash = '0;
    logic [15:0] m_max = 16'h600;

    logic       nxt_v = 0, nxt_a = 0, exp_v = 0, exp_a = 0;
    logic [2:0] nxt_r = 0, exp_r = 0;
    string      nxt_tag = "R2", exp_tag = "R2";

    localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER = 48'h02_99_88_77_66_55;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h01_00_5E_00_00_01;

    always #10 clk = ~clk;

    rx_addr_filter u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_valid(rx_valid), .rx_dst(rx_dst), .rx_src(rx_src), .rx_hash_idx(rx_hash_idx),
        .rx_len(rx_len), .rx_crc_bad(rx_crc_bad), .rx_len_bad(rx_len_bad),
        .rx_is_ctrl(rx_is_ctrl), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_reason(dec_reason)
    );

    function automatic logic [3:0] model(input logic [47:0] da, input logic [47:0] sa,
                                         input int hi, input int len,
                                         input logic crc, input logic lb, input logic cf);
        logic ok;
        int   code;
        if (m_ctrl[4]) return {1'b1, 3'd0};
        if (len < 64) return {1'b0, 3'd1};
        if (crc && !m_ctrl[6]) return {1'b0, 3'd1};
        if (lb && !m_ctrl[7]) return {1'b0, 3'd1};
        if (cf && !m_ctrl[5]) return {1'b0, 3'd1};
        if (len > int'(m_max) && !m_ctrl[8]) return {1'b0, 3'd1};
        if (da == BCAST) begin
            ok = m_ctrl[22]; code = 2;
        end else if (da[40]) begin
            code = 3;
            ok = m_ctrl[20];
            if (m_ctrl[21]) ok = ok && m_hash[hi];
        end else begin
            code = 4;
            ok = m_ctrl[17] ? (m_ctrl[16] && da == m_st) : 1'b1;
        end
        if (ok && m_ctrl[24]) begin
            if (!((sa == m_st) ^ m_ctrl[25])) begin ok = 0; code = 5; end
        end
        return {ok, 3'(code)};
    endfunction

    always @(posedge clk) begin
        if (rst) exp_v <= 0;
        else begin
            exp_v <= nxt_v; exp_a <= nxt_a; exp_r <= nxt_r; exp_tag <= nxt_tag;
        end
    end

    always @(posedge clk) begin
        #5;
        if (!rst) begin
            checks++;
            if (dec_valid !== exp_v) begin
                errors++;
                $display("FAIL R2 valid: actual=%0b expected=%0b", dec_valid, exp_v);
            end
            if (exp_v) begin
                checks++;
                if (dec_accept !== exp_a || dec_reason !== exp_r) begin
                    errors++;
                    $display("FAIL %s: actual acc=%0b rsn=%0d expected acc=%0b rsn=%0d",
                             exp_tag, dec_accept, dec_reason, exp_a, exp_r);
                end
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        cfg_we = 0; rx_valid = 0; nxt_v = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        rx_valid = 0; nxt_v = 0;
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        case (a)
            3'd0: m_ctrl = d;
            3'd1: m_st[47:24] = d[23:0];
            3'd2: m_st[23:0] = d[23:0];
            3'd3: m_hash[31:0] = d;
            3'd4: m_hash[63:32] = d;
            3'd5: m_max = d[15:0];
            default: ;
        endcase
    endtask

    task automatic frame(input string tag, input logic [47:0] da, input logic [47:0] sa,
                         input int hi, input int len,
                         input logic crc, input logic lb, input logic cf);
        logic [3:0] r;
        @(negedge clk);
        cfg_we = 0;
        rx_valid = 1; rx_dst = da; rx_src = sa; rx_hash_idx = 6'(hi);
        rx_len = 16'(len); rx_crc_bad = crc; rx_len_bad = lb; rx_is_ctrl = cf;
        r = model(da, sa, hi, len, crc, lb, cf);
        nxt_v = 1; nxt_a = r[3]; nxt_r = r[2:0]; nxt_tag = tag;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle(); idle();                                  // R1: dec_valid stays 0
        frame("R1", OTHER, OTHER, 0, 100, 0, 0, 0);      // defaults: unicast open
        frame("R1", OTHER, OTHER, 0, 2000, 0, 0, 0);     // over 0x600 passed by default
        // R10 station and R9 unicast
        wr(3'd1, 32'h021122); wr(3'd2, 32'h334455);
        wr(3'd0, 32'h0003_0100);
        frame("R9", STA, OTHER, 0, 100, 0, 0, 0);
        frame("R9", OTHER, OTHER, 0, 100, 0, 0, 0);
        frame("R10", 48'h02_11_22_33_44_54, OTHER, 0, 100, 0, 0, 0);
        wr(3'd0, 32'h0002_0100);
        frame("R9", STA, OTHER, 0, 100, 0, 0, 0);
        // R6 broadcast ahead of multicast
        wr(3'd0, 32'h0010_0100);
        frame("R6", BCAST, OTHER, 0, 100, 0, 0, 0);
        wr(3'd0, 32'h0040_0100);
        frame("R6", BCAST, OTHER, 0, 100, 0, 0, 0);
        // R7 / R8 multicast and hash
        frame("R7", MCAST, OTHER, 0, 100, 0, 0, 0);
        wr(3'd0, 32'h0010_0100);
        frame("R7", MCAST, OTHER, 0, 100, 0, 0, 0);
        wr(3'd0, 32'h0030_0100);
        wr(3'd4, 32'h0000_0020);
        frame("R8", MCAST, OTHER, 37, 100, 0, 0, 0);
        frame("R8", MCAST, OTHER, 5, 100, 0, 0, 0);
        wr(3'd3, 32'h0000_0020);
        frame("R8", MCAST, OTHER, 5, 100, 0, 0, 0);
        frame("R8", MCAST, OTHER, 36, 100, 0, 0, 0);
        // R4 error screening
        wr(3'd0, 32'h0000_0100);
        frame("R4", OTHER, OTHER, 0, 100, 1, 0, 0);
        frame("R4", OTHER, OTHER, 0, 100, 0, 1, 0);
        frame("R4", OTHER, OTHER, 0, 100, 0, 0, 1);
        wr(3'd0, 32'h0000_01E0);
        frame("R4", OTHER, OTHER, 0, 100, 1, 1, 1);
        // R5 lengths
        frame("R5", OTHER, OTHER, 0, 63, 0, 0, 0);
        frame("R5", OTHER, OTHER, 0, 64, 0, 0, 0);
        wr(3'd0, 32'h0000_0000);
        frame("R5", OTHER, OTHER, 0, 'h600, 0, 0, 0);
        frame("R5", OTHER, OTHER, 0, 'h601, 0, 0, 0);
        wr(3'd5, 32'h0000_0100);
        frame("R12", OTHER, OTHER, 0, 'h101, 0, 0, 0);
        frame("R12", OTHER, OTHER, 0, 'h100, 0, 0, 0);
        // R3 pass-all overrides everything
        wr(3'd0, 32'h0000_0010);
        frame("R3", OTHER, OTHER, 0, 10, 1, 1, 1);
        frame("R3", BCAST, OTHER, 0, 'h700, 0, 0, 0);
        // R11 source screen
        wr(3'd5, 32'h0000_0600);
        wr(3'd0, 32'h0100_0100);
        frame("R11", OTHER, STA, 0, 100, 0, 0, 0);
        frame("R11", OTHER, OTHER, 0, 100, 0, 0, 0);
        wr(3'd0, 32'h0300_0100);
        frame("R11", OTHER, STA, 0, 100, 0, 0, 0);
        frame("R11", OTHER, OTHER, 0, 100, 0, 0, 0);
        wr(3'd0, 32'h0102_0100);
        frame("R11", OTHER, STA, 0, 100, 0, 0, 0); // rejected by DA first: code 4
        // R12 unused addresses have no effect
        wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0003_0100);
        frame("R12", STA, OTHER, 0, 100, 0, 0, 0);
        frame("R12", OTHER, OTHER, 0, 100, 0, 0, 0);
        // R2 back-to-back frames followed by gap
        frame("R2", STA, OTHER, 0, 100, 0, 0, 0);
        frame("R2", BCAST, OTHER, 0, 100, 0, 0, 0);
        frame("R2", MCAST, OTHER, 0, 100, 0, 0, 0);
        idle(); idle(); idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule